// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block buffers data words between two unrelated clocks. A producer pushes words on the write clock and watches a full flag. A consumer pulls words on the read clock and watches an empty flag. Storage is a register array with one write port and one read port. Each port indexes the array with its own binary pointer, and each pointer is one bit wider than the array address. The extra top bit records how many times the pointer has wrapped.

Each domain needs to know the other's pointer. The source domain therefore converts its pointer to Gray code and keeps that Gray value in a register. The destination domain samples the Gray value through two flops per bit, with nothing between the flops. Only after the second flop is the value turned back into binary, using a top-down prefix XOR. The flags come from binary compares against these delayed, decoded views. A flag can stay set for a few cycles after the condition behind it has gone. It can never clear before the space or data it promises actually exists.

Top module: `afifo_gray`

## Requirements
- R1: While `rst` is high and after it falls, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0.
- R2: Every accepted word is read out once, unchanged and in write order, under any mix of write and read enables.
- R3: `wr_full` is set in the write cycle in which the write pointer becomes DEPTH ahead of the synchronized read pointer (top bits differ, address bits equal). It stays clear while DEPTH-1 or fewer unread words are held.
- R4: `rd_empty` is set on the read edge that accepts the last held word, because the read pointer then equals the synchronized write pointer. It is clear while words are visible to the read side.
- R5: A write while `wr_full` is 1 stores nothing and leaves the write pointer unchanged.
- R6: A read while `rd_empty` is 1 leaves the read pointer and `rd_data` unchanged.
- R7: `rd_data` is registered. It takes the next word on the read edge that accepts a read and holds its value on every other edge.
- R8: Flags are pessimistic, so neither side's view of the other's pointer is ever ahead of the true pointer. After a write into an empty FIFO, `rd_empty` is still 1 at the first read edge and is 0 within four read edges.
- R9: Each pointer moves only by +1 per accepted transfer. Its Gray register changes in at most one bit per cycle, including the wrap from all ones back to zero.
- R10: The destination-side decode is the prefix XOR: the top bit is copied, and each lower bit is the decoded bit above it XORed with the Gray bit. Re-encoding the decoded value reproduces the synchronized Gray vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rst | input | 1 | Active-high reset, synchronous in each domain, held across edges of both clocks |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room as seen from the write side |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | No data as seen from the read side |

## Verification
Embedded assertions check on every edge that each pointer advances by exactly one and that its Gray register changes in at most one bit, including at the wrap. They also check that the decoded view re-encodes to the synchronized vector, that neither remote view is ahead of the true pointer, that occupancy never exceeds the depth or goes below zero, and that a refused request moves nothing. Only the bench scenarios can show the rest. These are data integrity and order against a queue model under many enable ratios that wrap the pointers many times, the exact cycle on which full rises at the DEPTH-th word, the late clearing of empty after a first write, and `rd_data` holding through ignored reads.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    // Working width for the code conversions; pointer widths stay below it.
    localparam int WIDE_W = 32;

    typedef logic [WIDE_W-1:0] wide_t;

    // Binary to reflected Gray code.
    function automatic wide_t to_gray(wide_t b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary: copy the top bit, then chain XOR downward.
    // Upper zero bits decode to zero, so narrower values may be zero-extended.
    function automatic wide_t from_gray(wide_t g);
        wide_t b;
        b[WIDE_W-1] = g[WIDE_W-1];
        for (int i = WIDE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_ptr.sv
module afifo_ptr
    import afifo_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PTR_W-1:0] bin_q,
    output logic [PTR_W-1:0] gray_q
);

    logic [PTR_W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    // Gray register is loaded from the next binary value so both move on one edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (step) begin
            bin_q  <= bin_nxt;
            gray_q <= PTR_W'(to_gray(wide_t'(bin_nxt)));
        end
    end

    AST_PTR_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(bin_q) |-> (bin_q == $past(bin_q) + 1'b1));   // R9

    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1);             // R9

endmodule

// File: rtl/afifo_sync.sv
module afifo_sync
    import afifo_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);

    logic [PTR_W-1:0] synced;

    // One independent two-flop chain per Gray bit, wire only between stages.
    for (genvar b = 0; b < PTR_W; b++) begin : g_bit
        logic meta_q;
        logic hold_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= gray_in[b];
                hold_q <= meta_q;
            end
        end
        assign synced[b] = hold_q;
    end

    // Decode strictly downstream of the second stage.
    assign bin_out = PTR_W'(from_gray(wide_t'(synced)));

    AST_DECODE_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
        PTR_W'(to_gray(wide_t'(bin_out))) == synced);         // R10

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/afifo_gray.sv
module afifo_gray #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int               PTR_W   = ADDR_W + 1;
    localparam int               DEPTH   = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] WRAP_X  = {1'b1, {ADDR_W{1'b0}}};

    logic [PTR_W-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PTR_W-1:0] wr_seen, rd_seen;
    logic             wr_step, rd_step;

    assign wr_step = wr_en & ~wr_full;
    assign rd_step = rd_en & ~rd_empty;

    afifo_ptr #(.PTR_W(PTR_W)) wptr_i (
        .clk(wr_clk), .rst(rst), .step(wr_step), .bin_q(wr_bin), .gray_q(wr_gray)
    );

    afifo_ptr #(.PTR_W(PTR_W)) rptr_i (
        .clk(rd_clk), .rst(rst), .step(rd_step), .bin_q(rd_bin), .gray_q(rd_gray)
    );

    // Write pointer into the read domain, read pointer into the write domain.
    afifo_sync #(.PTR_W(PTR_W)) w2r_i (
        .clk(rd_clk), .rst(rst), .gray_in(wr_gray), .bin_out(wr_seen)
    );

    afifo_sync #(.PTR_W(PTR_W)) r2w_i (
        .clk(wr_clk), .rst(rst), .gray_in(rd_gray), .bin_out(rd_seen)
    );

    afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wclk(wr_clk), .we(wr_step), .waddr(wr_bin[ADDR_W-1:0]), .wdata(wr_data),
        .rclk(rd_clk), .rst(rst), .re(rd_step), .raddr(rd_bin[ADDR_W-1:0]),
        .rdata(rd_data)
    );

    // Full: wrap bits differ, address bits equal. Empty: pointers equal.
    assign wr_full  = (wr_bin ^ rd_seen) == WRAP_X;
    assign rd_empty = (rd_bin == wr_seen);

    // Occupancy and lag views used only by the checks below.
    logic [PTR_W-1:0] wr_fill, rd_fill, wr_lag, rd_lag;
    assign wr_fill = wr_bin - rd_seen;
    assign rd_fill = wr_seen - rd_bin;
    assign wr_lag  = wr_bin - wr_seen;
    assign rd_lag  = rd_bin - rd_seen;

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
        wr_fill <= DEPTH_P);                                   // R3

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst)
        rd_fill <= DEPTH_P);                                   // R4

    AST_FULL_WRITE_IGNORED: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_en && wr_full) |=> $stable(wr_bin));               // R5

    AST_EMPTY_READ_IGNORED: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_en && rd_empty) |=> ($stable(rd_bin) && $stable(rd_data))); // R6

    AST_WR_VIEW_NOT_AHEAD: assert property (@(posedge rd_clk) disable iff (rst)
        wr_lag <= DEPTH_P);                                    // R8

    AST_RD_VIEW_NOT_AHEAD: assert property (@(posedge wr_clk) disable iff (rst)
        rd_lag <= DEPTH_P);                                    // R8

endmodule

// File: tb/afifo_gray_tb_top.sv
module afifo_gray_tb_top;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst    = 1'b1;
    logic          wr_en  = 1'b0;
    logic          rd_en  = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, rd_empty;
    logic [DW-1:0] rd_data;

    int checks   = 0;
    int failures = 0;
    logic [DW-1:0] model_q [$];
    bit wdone;

    afifo_gray #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    // 250 MHz write clock (4 ns); read clock period 7 ns, co-prime with it.
    always #2 wr_clk = ~wr_clk;
    initial forever begin
        #4 rd_clk = 1'b1;
        #3 rd_clk = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Writes n cycles with given percent enable; data random or sequential from base.
    task automatic writer(input int n, input int pct, input bit seq, input int base);
        for (int i = 0; i < n; i++) begin
            @(posedge wr_clk); #1;
            wr_en   = ($urandom_range(99) < pct);
            wr_data = seq ? DW'(base + i) : DW'($urandom_range(255));
            @(negedge wr_clk);
            if (wr_en && !wr_full) model_q.push_back(wr_data);
        end
        @(posedge wr_clk); #1;
        wr_en = 1'b0;
    endtask

    // Reads until the writer is done and the model is drained; checks each word. R2
    task automatic reader(input int pct);
        bit            pend = 1'b0;
        logic [DW-1:0] exp_w = '0;
        while (!(wdone && model_q.size() == 0 && !pend)) begin
            @(posedge rd_clk); #1;
            if (pend) begin
                chk(rd_data == exp_w, "R2 data order", rd_data, exp_w);
                pend = 1'b0;
            end
            rd_en = ($urandom_range(99) < pct);
            @(negedge rd_clk);
            if (rd_en && !rd_empty) begin
                if (model_q.size() == 0) begin
                    chk(1'b0, "R4 read accepted with nothing written", 1, 0);
                end else begin
                    exp_w = model_q.pop_front();
                    pend  = 1'b1;
                end
            end
        end
        rd_en = 1'b0;
    endtask

    task automatic phase(input int n, input int pw, input int pr);
        wdone = 1'b0;
        fork
            begin
                writer(n, pw, 1'b0, 0);
                wdone = 1'b1;
            end
            reader(pr);
        join
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge rd_clk);
        @(posedge wr_clk); #1;
        chk(rd_empty == 1'b1, "R1 empty during reset", rd_empty, 1);
        chk(wr_full == 1'b0, "R1 full during reset", wr_full, 0);
        rst = 1'b0;
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        chk(rd_empty == 1'b1, "R1 empty after reset", rd_empty, 1);
        chk(wr_full == 1'b0, "R1 full after reset", wr_full, 0);
        chk(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

        // Single word into an empty FIFO: empty clears late, never early.
        writer(1, 100, 1'b1, 8'hA5);
        @(posedge rd_clk); #1;
        chk(rd_empty == 1'b1, "R8 empty still set one read edge after write", rd_empty, 1);
        repeat (3) @(posedge rd_clk); #1;
        chk(rd_empty == 1'b0, "R8 empty clears within four read edges", rd_empty, 0);
        rd_en = 1'b1;
        @(negedge rd_clk);
        void'(model_q.pop_front());
        @(posedge rd_clk); #1;
        rd_en = 1'b0;
        chk(rd_data == 8'hA5, "R7 rd_data updates on accepting edge", rd_data, 8'hA5);
        chk(rd_empty == 1'b1, "R4 empty on edge taking last word", rd_empty, 1);
        @(posedge rd_clk); #1;
        chk(rd_data == 8'hA5, "R7 rd_data holds without read", rd_data, 8'hA5);

        // Reads while empty are ignored.
        rd_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge rd_clk); #1;
            chk(rd_data == 8'hA5, "R6 rd_data unchanged by read while empty", rd_data, 8'hA5);
            chk(rd_empty == 1'b1, "R6 still empty", rd_empty, 1);
        end
        rd_en = 1'b0;

        // Fill to DEPTH-1: not full. One more: full on that write edge.
        writer(DEPTH - 1, 100, 1'b1, 8'h10);
        repeat (6) @(posedge rd_clk);
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R3 not full with DEPTH-1 words", wr_full, 0);
        @(posedge wr_clk); #1;
        wr_en = 1'b1; wr_data = 8'h1F;
        @(negedge wr_clk);
        if (!wr_full) model_q.push_back(wr_data);
        @(posedge wr_clk); #1;
        wr_en = 1'b0;
        @(negedge wr_clk);
        chk(wr_full == 1'b1, "R3 full on DEPTH-th write", wr_full, 1);

        // Writes while full are dropped; draining shows no extra word.
        writer(4, 100, 1'b1, 8'hE0);
        @(negedge wr_clk);
        chk(wr_full == 1'b1, "R5 still full after refused writes", wr_full, 1);
        chk(model_q.size() == DEPTH, "R5 model depth", model_q.size(), DEPTH);
        wdone = 1'b1;
        reader(100);
        @(posedge rd_clk); #1;
        rd_en = 1'b1;
        @(posedge rd_clk); #1;
        rd_en = 1'b0;
        chk(rd_data == 8'h1F, "R5 last word kept, no refused word stored", rd_data, 8'h1F);
        chk(rd_empty == 1'b1, "R4 empty after drain", rd_empty, 1);
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R3 full clears after drain", wr_full, 0);

        // Sweep of enable ratios; each wraps the pointers many times. R9 R10
        phase(300, 90, 30);
        phase(300, 30, 90);
        phase(300, 70, 70);
        phase(300, 100, 100);
        phase(300, 50, 20);
        phase(300, 15, 60);
        repeat (6) @(posedge rd_clk); #1;
        chk(rd_empty == 1'b1, "R4 empty after sweep", rd_empty, 1);
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R3 not full after sweep", wr_full, 0);

        summary();
        $finish;
    end

endmodule